// File: doc/BRIEF.md
# Raw Sector Signature Scanner

This block finds a boot image on a removable block device without reading any filesystem structure. It first asks for card initialization. It then reads raw sectors one at a time, starting at sector 0 and counting upward. In each sector it looks at one 32-bit word at a fixed byte position and compares it with the boot magic value 0x43484950. When a sector carries the magic, the block reads that sector again from its first byte. It writes that sector, and the sectors after it, into a word-wide hub memory port until a full image has been copied.

Because the search is linear, one loader handles several card layouts: images written to raw sectors, images in the first sector of a partitioned card, images in the reserved area, and image files on a freshly formatted card. A failure has two causes: the card rejects initialization, or no magic is found within the search limit. On failure the chip-select line blinks a fixed number of times, then the block reports completion with the success flag low. The card command protocol is not part of this block. It is reduced to an init handshake, a sector request, and a byte stream.

Top module: `sector_boot_scanner`

## Requirements
- R1: While reset is applied and directly after it, `cs_n` is 1, and `done`, `ok`, `init_req`, `rd_req` and `hub_we` are all 0.
- R2: After `start`, `init_req` stays high until `init_done`. If `init_ok` is 0 at `init_done`, the attempt fails at once and no sector is requested.
- R3: During the search, `rd_req` is a one-cycle pulse. `rd_sector` is 0 for the first request and one higher for each later request. A new request is issued only after the byte flagged `st_last` of the previous sector.
- R4: A sector matches only when its bytes at offsets SIG_OFFSET to SIG_OFFSET+3 form 0x43484950 in little-endian order (the byte at SIG_OFFSET is 0x50). The same four bytes at any other offset do not count as a match.
- R5: After a match, the matching sector is requested again, followed by the sectors after it in increasing order. Every 4 received bytes form one hub word {b3,b2,b1,b0}. Hub word addresses start at 0 and increase by 1 per write. No hub write happens during the search.
- R6: A successful load makes exactly IMG_BYTES/4 hub writes and then raises `done` with `ok`=1. `ok` is never 1 while `done` is 0.
- R7: If none of sectors 0 to SCAN_LIMIT-1 matches, exactly SCAN_LIMIT sectors are read, nothing is written, and the attempt fails.
- R8: On failure, `cs_n` gives BLINKS low pulses. Each pulse lasts BLINK_HALF cycles, and each is preceded by BLINK_HALF high cycles. After the pulses, `done` rises with `ok`=0. No request and no write occur during the blinking.
- R9: `cs_n` is 0 without a break from the start of initialization to the end of the last sector transfer.
- R10: `done` and `ok` hold their values until the next `start`. A `start` while `done` is high begins a new attempt from sector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a boot attempt when idle or done |
| init_req | output | 1 | Card initialization in progress |
| init_done | input | 1 | Initialization finished (one-cycle pulse) |
| init_ok | input | 1 | Initialization result, valid with init_done |
| rd_req | output | 1 | One-cycle sector read request |
| rd_sector | output | SECT_AW | Sector number for rd_req |
| st_valid | input | 1 | Sector byte valid |
| st_data | input | 8 | Sector byte |
| st_last | input | 1 | Marks the final byte of a sector |
| hub_we | output | 1 | Hub word write strobe |
| hub_addr | output | HUB_AW | Hub word address |
| hub_wdata | output | 32 | Hub write data |
| cs_n | output | 1 | Card select, active low; also the failure blink |
| done | output | 1 | Attempt finished |
| ok | output | 1 | Image loaded (valid with done) |

## Verification
The bench builds the block with small parameter values:
- 16-byte sectors.
- A signature offset of 6, which is not word aligned.
- A search limit of 6 sectors.
- A 64-byte image of 4 sectors.
- 2 blinks of 3 cycles each.

With these sizes the bench can place the magic at every sector inside the search window. It also places it one sector past the window, and it places decoy magics one byte off the real offset. Each placement is a separate attempt. Loads that run past the search limit can be checked word by word against bytes computed in the bench. The short blink gives pulse widths and counts that can be checked exactly. Byte streams with and without idle gaps, init rejection, and restart from the done state each run as their own attempt.

// File: rtl/bootscan_pkg.sv
package bootscan_pkg;

  localparam logic [31:0] BOOT_MAGIC = 32'h4348_4950;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_REQ,
    ST_RECV,
    ST_EVAL,
    ST_BLINK,
    ST_DONE
  } scan_state_e;

  // Little-endian window: the newest byte enters at the top.
  function automatic logic [31:0] shift_in_byte(input logic [31:0] win, input logic [7:0] b);
    return {b, win[31:8]};
  endfunction

  function automatic logic is_boot_magic(input logic [31:0] w);
    return w == BOOT_MAGIC;
  endfunction

endpackage

// File: rtl/bs_word_packer.sv
module bs_word_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic [31:0] win_next,
  output logic        word_valid,
  output logic [31:0] word
);
  import bootscan_pkg::*;

  logic [31:0] win_q;
  logic [1:0]  lane_q;

  assign win_next = shift_in_byte(win_q, in_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q      <= '0;
      lane_q     <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else if (clr) begin
      lane_q     <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= in_valid && (lane_q == 2'd3);
      if (in_valid) begin
        win_q  <= win_next;
        lane_q <= lane_q + 2'd1;
        if (lane_q == 2'd3) word <= win_next;
      end
    end
  end
endmodule

// File: rtl/bs_blinker.sv
module bs_blinker #(
  parameter int COUNT = 3,
  parameter int HALF  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic level,
  output logic finish
);
  localparam int LAST_PH = 2 * COUNT - 1;
  localparam int PH_W    = $clog2(2 * COUNT + 1);
  localparam int CNT_W   = $clog2(HALF + 1);

  logic             busy_q;
  logic [PH_W-1:0]  ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             phase_end;

  assign phase_end = busy_q && (cnt_q == CNT_W'(HALF - 1));
  assign finish    = phase_end && (ph_q == PH_W'(LAST_PH));
  // even phases high, odd phases low
  assign level     = busy_q ? ~ph_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      cnt_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      ph_q   <= '0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (phase_end) begin
        cnt_q <= '0;
        if (finish) busy_q <= 1'b0;
        else        ph_q   <= ph_q + PH_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sector_boot_scanner.sv
module sector_boot_scanner #(
  parameter int SECT_BYTES = 512,
  parameter int SIG_OFFSET = 8,
  parameter int SCAN_LIMIT = 512,
  parameter int IMG_BYTES  = 131072,
  parameter int BLINKS     = 3,
  parameter int BLINK_HALF = 2_500_000,
  parameter int SECT_AW    = 32,
  localparam int HUB_AW    = $clog2(IMG_BYTES / 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               init_req,
  input  logic               init_done,
  input  logic               init_ok,
  output logic               rd_req,
  output logic [SECT_AW-1:0] rd_sector,
  input  logic               st_valid,
  input  logic [7:0]         st_data,
  input  logic               st_last,
  output logic               hub_we,
  output logic [HUB_AW-1:0]  hub_addr,
  output logic [31:0]        hub_wdata,
  output logic               cs_n,
  output logic               done,
  output logic               ok
);
  import bootscan_pkg::*;

  localparam int IMG_SECTORS = IMG_BYTES / SECT_BYTES;
  localparam int BYTE_W      = $clog2(SECT_BYTES + 1);
  localparam int LOAD_W      = $clog2(IMG_SECTORS + 1);
  localparam int SIG_END     = SIG_OFFSET + 3;

  scan_state_e        st_q, st_d;
  logic [SECT_AW-1:0] sec_q;
  logic [BYTE_W-1:0]  bcnt_q;
  logic               hit_q;
  logic               load_q;
  logic [LOAD_W-1:0]  loaded_q;
  logic [HUB_AW-1:0]  waddr_q;
  logic               ok_q;

  // named internal events
  logic        active;
  logic        scan_phase;
  logic        load_phase;
  logic        blink_phase;
  logic        load_complete;
  logic        scan_exhausted;
  logic        byte_take;
  logic        sig_byte;
  logic [31:0] pk_win_next;
  logic        pk_word_valid;
  logic [31:0] pk_word;
  logic        blk_go;
  logic        blk_level;
  logic        blk_finish;

  assign active         = (st_q == ST_INIT) || (st_q == ST_REQ) ||
                          (st_q == ST_RECV) || (st_q == ST_EVAL);
  assign scan_phase     = active && !load_q;
  assign load_phase     = active && load_q;
  assign blink_phase    = (st_q == ST_BLINK);
  assign load_complete  = (loaded_q == LOAD_W'(IMG_SECTORS));
  assign scan_exhausted = (sec_q == SECT_AW'(SCAN_LIMIT - 1));
  assign byte_take      = (st_q == ST_RECV) && st_valid;
  assign sig_byte       = byte_take && !load_q && (bcnt_q == BYTE_W'(SIG_END));

  bs_word_packer u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (st_q == ST_REQ),
    .in_valid  (byte_take),
    .in_data   (st_data),
    .win_next  (pk_win_next),
    .word_valid(pk_word_valid),
    .word      (pk_word)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (start) st_d = ST_INIT;
      ST_INIT:  if (init_done) st_d = init_ok ? ST_REQ : ST_BLINK;
      ST_REQ:   st_d = ST_RECV;
      ST_RECV:  if (st_valid && st_last) st_d = ST_EVAL;
      ST_EVAL: begin
        if (load_q)              st_d = load_complete ? ST_DONE : ST_REQ;
        else if (hit_q)          st_d = ST_REQ;
        else if (scan_exhausted) st_d = ST_BLINK;
        else                     st_d = ST_REQ;
      end
      ST_BLINK: if (blk_finish) st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign blk_go = (st_d == ST_BLINK) && (st_q != ST_BLINK);

  bs_blinker #(
    .COUNT(BLINKS),
    .HALF (BLINK_HALF)
  ) u_blinker (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (blk_go),
    .level (blk_level),
    .finish(blk_finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sec_q    <= '0;
      bcnt_q   <= '0;
      hit_q    <= 1'b0;
      load_q   <= 1'b0;
      loaded_q <= '0;
      waddr_q  <= '0;
      ok_q     <= 1'b0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            ok_q     <= 1'b0;
            sec_q    <= '0;
            load_q   <= 1'b0;
            loaded_q <= '0;
          end
        end
        ST_REQ: begin
          bcnt_q <= '0;
          hit_q  <= 1'b0;
        end
        ST_RECV: begin
          if (st_valid) begin
            bcnt_q <= bcnt_q + BYTE_W'(1);
            if (sig_byte) hit_q <= is_boot_magic(pk_win_next);
            if (st_last && load_q) loaded_q <= loaded_q + LOAD_W'(1);
          end
        end
        ST_EVAL: begin
          if (load_q) begin
            if (load_complete) ok_q <= 1'b1;
            else               sec_q <= sec_q + SECT_AW'(1);
          end else if (hit_q) begin
            load_q <= 1'b1;          // re-read this sector as image sector 0
          end else if (!scan_exhausted) begin
            sec_q <= sec_q + SECT_AW'(1);
          end
        end
        default: ;
      endcase
      if (st_q == ST_INIT)  waddr_q <= '0;
      else if (hub_we)      waddr_q <= waddr_q + HUB_AW'(1);
    end
  end

  assign init_req  = (st_q == ST_INIT);
  assign rd_req    = (st_q == ST_REQ);
  assign rd_sector = sec_q;
  assign hub_we    = pk_word_valid && load_q;
  assign hub_addr  = waddr_q;
  assign hub_wdata = pk_word;
  assign cs_n      = active ? 1'b0 : (blink_phase ? blk_level : 1'b1);
  assign done      = (st_q == ST_DONE);
  assign ok        = ok_q;

endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int SECT_AW = 32,
  parameter int HUB_AW  = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               init_req,
  input logic               init_done,
  input logic               rd_req,
  input logic [SECT_AW-1:0] rd_sector,
  input logic               hub_we,
  input logic [HUB_AW-1:0]  hub_addr,
  input logic               cs_n,
  input logic               done,
  input logic               ok,
  input logic               scan_phase,
  input logic               load_phase,
  input logic               blink_phase
);
  logic               ps_valid;
  logic [SECT_AW-1:0] ps_sec;
  logic               pa_valid;
  logic [HUB_AW-1:0]  pa_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_valid <= 1'b0;
      ps_sec   <= '0;
      pa_valid <= 1'b0;
      pa_addr  <= '0;
    end else begin
      if (init_req) ps_valid <= 1'b0;
      else if (rd_req && scan_phase) begin
        ps_valid <= 1'b1;
        ps_sec   <= rd_sector;
      end
      if (init_req) pa_valid <= 1'b0;
      else if (hub_we) begin
        pa_valid <= 1'b1;
        pa_addr  <= hub_addr;
      end
    end
  end

  assert_init_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_req && !init_done |=> init_req);
  assert_init_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |-> !rd_req);
  assert_scan_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && scan_phase && !ps_valid |-> rd_sector == '0);
  assert_scan_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && scan_phase && ps_valid |-> rd_sector == ps_sec + SECT_AW'(1));
  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_write_only_loading_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hub_we |-> load_phase);
  assert_addr_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hub_we && !pa_valid |-> hub_addr == '0);
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hub_we && pa_valid |-> hub_addr == pa_addr + HUB_AW'(1));
  assert_ok_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> done);
  assert_blink_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blink_phase |-> !rd_req && !hub_we && !done);
  assert_cs_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || hub_we || init_req) |-> !cs_n);
  assert_done_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(ok));
endmodule

bind sector_boot_scanner bs_checker #(
  .SECT_AW(SECT_AW),
  .HUB_AW (HUB_AW)
) u_bs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .init_req   (init_req),
  .init_done  (init_done),
  .rd_req     (rd_req),
  .rd_sector  (rd_sector),
  .hub_we     (hub_we),
  .hub_addr   (hub_addr),
  .cs_n       (cs_n),
  .done       (done),
  .ok         (ok),
  .scan_phase (scan_phase),
  .load_phase (load_phase),
  .blink_phase(blink_phase)
);

// File: tb/sector_boot_scanner_bench.sv
module sector_boot_scanner_bench;
  localparam int SB = 16, SO = 6, SL = 6, IB = 64, BL = 2, BH = 3, SAW = 16, HAW = 4;
  localparam int IMG_SEC = IB / SB;
  localparam int IMG_W   = IB / 4;
  localparam logic [31:0] MAGIC = 32'h4348_4950;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n, start, init_done, init_ok, st_valid, st_last;
  logic [7:0]     st_data;
  logic           init_req, rd_req, hub_we, cs_n, done, ok;
  logic [SAW-1:0] rd_sector;
  logic [HAW-1:0] hub_addr;
  logic [31:0]    hub_wdata;

  sector_boot_scanner #(
    .SECT_BYTES(SB), .SIG_OFFSET(SO), .SCAN_LIMIT(SL), .IMG_BYTES(IB),
    .BLINKS(BL), .BLINK_HALF(BH), .SECT_AW(SAW)
  ) u_sector_boot_scanner (
    .clk(clk), .rst_n(rst_n), .start(start),
    .init_req(init_req), .init_done(init_done), .init_ok(init_ok),
    .rd_req(rd_req), .rd_sector(rd_sector),
    .st_valid(st_valid), .st_data(st_data), .st_last(st_last),
    .hub_we(hub_we), .hub_addr(hub_addr), .hub_wdata(hub_wdata),
    .cs_n(cs_n), .done(done), .ok(ok)
  );

  int checks = 0, errors = 0;
  int sig_sec = -1, decoy_sec = -1, gap_mode = 0, init_good = 1;
  int reads [0:63];
  int nreads = 0, nwrites = 0, addr_err = 0;
  logic [31:0] mem [0:IMG_W-1];
  int runs [0:15];
  int nruns = 0, cur_run = 0;

  // disk model: magic at SO of sig_sec, decoy one byte later in decoy_sec
  function automatic int db(input int s, input int i);
    if (s == sig_sec && i >= SO && i < SO + 4) return int'((MAGIC >> (8 * (i - SO))) & 32'hFF);
    if (s == decoy_sec && i >= SO + 1 && i < SO + 5) return int'((MAGIC >> (8 * (i - SO - 1))) & 32'hFF);
    return (s * 37 + i * 11 + 5) % 256;
  endfunction

  function automatic logic [31:0] exp_word(input int first, input int w);
    int s, base;
    logic [31:0] e;
    s = first + w / (SB / 4);
    base = (w % (SB / 4)) * 4;
    e = '0;
    for (int b = 0; b < 4; b++) e = e + (32'(db(s, base + b)) << (8 * b));
    return e;
  endfunction

  task automatic chk(input bit cond, input string tag, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req) begin
        if (nreads < 64) reads[nreads] = int'(rd_sector);
        nreads++;
      end
      if (hub_we) begin
        if (int'(hub_addr) != nwrites) addr_err++;
        mem[hub_addr] = hub_wdata;
        nwrites++;
      end
      if (!cs_n) cur_run++;
      else if (cur_run > 0) begin
        if (nruns < 16) runs[nruns] = cur_run;
        nruns++;
        cur_run = 0;
      end
    end
  end

  // card model responder
  initial begin
    int s;
    init_done = 1'b0; init_ok = 1'b0; st_valid = 1'b0; st_data = '0; st_last = 1'b0;
    @(negedge clk);
    forever begin
      if (init_req && !init_done) begin
        repeat (3) @(negedge clk);
        init_done = 1'b1; init_ok = (init_good != 0);
        @(negedge clk);
        init_done = 1'b0; init_ok = 1'b0;
      end else if (rd_req) begin
        s = int'(rd_sector);
        for (int i = 0; i < SB; i++) begin
          @(negedge clk);
          if (gap_mode != 0 && (i % 3) == 1) begin
            st_valid = 1'b0; st_last = 1'b0;
            @(negedge clk);
          end
          st_valid = 1'b1; st_data = 8'(db(s, i)); st_last = (i == SB - 1);
        end
        @(negedge clk);
        st_valid = 1'b0; st_last = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // kind: 0 success, 1 search exhausted, 2 init rejected
  task automatic run_case(input int sg, input int dc, input int gm, input int ig, input int kind);
    int wd;
    sig_sec = sg; decoy_sec = dc; gap_mode = gm; init_good = ig;
    nreads = 0; nwrites = 0; addr_err = 0; nruns = 0; cur_run = 0;
    for (int w = 0; w < IMG_W; w++) mem[w] = 32'hDEAD_BEEF;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wd = 0;
    while (!done && wd < 20000) begin @(negedge clk); wd++; end
    chk(done, "watchdog R6/R8 done", done, 1);
    repeat (3) @(negedge clk);
    chk(done, "R10 done held", done, 1);
    if (kind == 0) begin
      chk(ok == 1'b1, "R6 ok", ok, 1);
      chk(nwrites == IMG_W, "R6 write count", nwrites, IMG_W);
      chk(addr_err == 0, "R5 address sequence", addr_err, 0);
      chk(nreads == sg + 1 + IMG_SEC, "R4 read count (decoy ignored)", nreads, sg + 1 + IMG_SEC);
      for (int i = 0; i <= sg; i++) chk(reads[i] == i, "R3 search order", reads[i], i);
      for (int k = 0; k < IMG_SEC; k++)
        chk(reads[sg + 1 + k] == sg + k, "R5 load order", reads[sg + 1 + k], sg + k);
      for (int w = 0; w < IMG_W; w++)
        chk(mem[w] == exp_word(sg, w), "R5 image word", mem[w], exp_word(sg, w));
      chk(nruns == 1, "R9 single cs_n low span", nruns, 1);
    end else begin
      chk(ok == 1'b0, "R7/R2 failure ok", ok, 0);
      chk(nwrites == 0, "R5 no writes on failure", nwrites, 0);
      if (kind == 1) begin
        chk(nreads == SL, "R7 sectors read", nreads, SL);
        for (int i = 0; i < SL; i++) chk(reads[i] == i, "R3 search order", reads[i], i);
      end else begin
        chk(nreads == 0, "R2 no read after init reject", nreads, 0);
      end
      chk(nruns == 1 + BL, "R8 blink count", nruns, 1 + BL);
      for (int b = 1; b <= BL && b < 16; b++)
        chk(runs[b] == BH, "R8 blink width", runs[b], BH);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R6 run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && done == 1'b0 && ok == 1'b0, "R1 reset outputs", {cs_n, done, ok}, 3'b100);
    chk(!init_req && !rd_req && !hub_we, "R1 reset strobes", {init_req, rd_req, hub_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1 && done == 1'b0 && !rd_req && !hub_we, "R1 after reset", {cs_n, done}, 2'b10);
    // every search position, alternating gaps, decoy in the previous sector
    for (int s = 0; s < SL; s++) run_case(s, (s > 0) ? s - 1 : -1, s % 2, 1, 0);
    run_case(-1, 2, 1, 1, 1);   // R4 decoy only, R7 exhausted
    run_case(SL, -1, 0, 1, 1);  // R7 magic just past the limit
    run_case(1, -1, 0, 0, 2);   // R2 init rejected
    run_case(3, 0, 1, 1, 0);    // R10 restart after failure
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule